// File: doc/BRIEF.md
# Transition Register Ownership Lock

This block decides which of two requesters may change a shared group of transition registers: a software bus port and a debug TAP port. The group holds a start command, a control field, a target-state field, a vendor-test field and a token of several 32-bit words. A requester asks for ownership by writing a fixed 8-bit key to the claim register. It then reads the claim register back. The key comes back only to the port that now owns the lock, and the other port reads zero.

The owner gets a per-port write-enable flag. Only a port whose flag is set can change the shared registers. Writes from any other port are dropped without effect. A busy input from the transition sequencer forces both flags low while a transition runs, and the owner keeps its claim during that time. Both ports read the same copy of the shared registers. Both ports use a plain write strobe with address and data, and a combinational read selected by address.

Top module: `xfer_lock`

## Requirements
- R1: After reset the lock is free. Both enable flags are 0. Every readable register reads 0. The start pulse is 0.
- R2: When the lock is free, a write of 0x5A to the claim register (address 0, bits 7:0) gives that port ownership from the next cycle on. From then on, that port reads 0x5A at address 0 and has its enable flag at 1. The other port reads 0 at address 0.
- R3: If both ports write 0x5A to the claim register in the same cycle while the lock is free, the TAP port gets ownership. The software port reads 0 at address 0.
- R4: While one port owns the lock, a claim write of 0x5A from the other port leaves ownership unchanged.
- R5: A claim write whose low byte is neither 0x5A nor 0x00 has no effect on ownership.
- R6: The owner releases the lock by writing 0x00 to the claim register. After that both ports read 0 at address 0 and both enable flags are 0. A release written by the port that does not own the lock is ignored.
- R7: While busy_i is 1, both enable flags are 0 in that same cycle and shared-register writes are dropped. Ownership is kept: the owner still reads 0x5A, and its flag returns when busy_i falls.
- R8: A write to a shared register from a port whose enable flag is 0 leaves the register unchanged.
- R9: A write from the enabled port lands at the next clock edge. The value is then visible on the outputs and to both ports. The address map is: control at 3, target at 4, vendor-test at 5, token word i at 8+i.
- R10: Writing 1 in bit 0 to the command register (address 2) with the enable flag set makes start_o high for exactly the one cycle after the write. The command register reads 0. Writing 0 there produces no pulse.
- R11: Address 1 reads the reading port's own enable flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Transition in progress; withdraws both enables |
| sw_wr_i | input | 1 | Software port write strobe |
| sw_addr_i | input | 4 | Software port register address |
| sw_wdata_i | input | 32 | Software port write data |
| sw_rdata_o | output | 32 | Software port read data for sw_addr_i |
| tap_wr_i | input | 1 | TAP port write strobe |
| tap_addr_i | input | 4 | TAP port register address |
| tap_wdata_i | input | 32 | TAP port write data |
| tap_rdata_o | output | 32 | TAP port read data for tap_addr_i |
| sw_en_o | output | 1 | Software port holds write permission |
| tap_en_o | output | 1 | TAP port holds write permission |
| start_o | output | 1 | One-cycle transition start pulse |
| ctrl_o | output | 1 | Control field |
| target_o | output | 5 | Target-state field |
| vtest_o | output | 32 | Vendor-test field |
| token_o | output | 128 | Token, word 0 in the low bits |

## Verification
Ownership, register contents and the start pulse come from registers. Each of them is due in the cycle after the clock edge that takes the write. The enable flags also depend on busy_i combinationally, so they change in the same cycle busy_i changes. Read data is combinational from the address. The bench drives all inputs at the falling edge. It queues each expected value and samples it shortly after that falling edge: one falling edge after a write, or in the same cycle for busy_i and address changes. The start pulse is checked once in the cycle after the command write and once more a cycle later, where it must be low.

// File: rtl/xl_pkg.sv
package xl_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_SW   = 2'd1,
    OWN_TAP  = 2'd2
  } owner_e;

  localparam int unsigned AddrW = 4;
  localparam logic [AddrW-1:0] A_CLAIM  = 4'd0;
  localparam logic [AddrW-1:0] A_EN     = 4'd1;
  localparam logic [AddrW-1:0] A_CMD    = 4'd2;
  localparam logic [AddrW-1:0] A_CTRL   = 4'd3;
  localparam logic [AddrW-1:0] A_TARGET = 4'd4;
  localparam logic [AddrW-1:0] A_VTEST  = 4'd5;
  localparam int unsigned      TokBase  = 8;
endpackage

// File: rtl/xl_arbiter.sv
module xl_arbiter #(
  parameter int unsigned ClaimW   = 8,
  parameter logic [ClaimW-1:0] ClaimKey = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_claim_wr_i,
  input  logic [ClaimW-1:0] sw_claim_val_i,
  input  logic              tap_claim_wr_i,
  input  logic [ClaimW-1:0] tap_claim_val_i,
  output xl_pkg::owner_e    owner_o
);
  import xl_pkg::*;

  owner_e owner_q, owner_d;
  logic   sw_take, sw_drop, tap_take, tap_drop, owner_upd;

  always_comb begin
    sw_take  = sw_claim_wr_i  && (sw_claim_val_i  == ClaimKey);
    sw_drop  = sw_claim_wr_i  && (sw_claim_val_i  == '0);
    tap_take = tap_claim_wr_i && (tap_claim_val_i == ClaimKey);
    tap_drop = tap_claim_wr_i && (tap_claim_val_i == '0);
    owner_d  = owner_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (tap_take)     owner_d = OWN_TAP;
        else if (sw_take) owner_d = OWN_SW;
      end
      OWN_SW:  if (sw_drop)  owner_d = OWN_NONE;
      OWN_TAP: if (tap_drop) owner_d = OWN_NONE;
      default: owner_d = OWN_NONE;
    endcase
    owner_upd = (owner_d != owner_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        owner_q <= OWN_NONE;
    else if (owner_upd) owner_q <= owner_d;
  end

  assign owner_o = owner_q;

  AST_FREE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && sw_take && !tap_take) |=> (owner_q == OWN_SW)); // R2
  AST_TAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && sw_take && tap_take) |=> (owner_q == OWN_TAP)); // R3
  AST_SW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_SW && !sw_drop) |=> (owner_q == OWN_SW)); // R4
  AST_OWNER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_TAP && tap_drop) |=> (owner_q == OWN_NONE)); // R6
endmodule

// File: rtl/xl_regfile.sv
module xl_regfile #(
  parameter int unsigned DataW    = 32,
  parameter int unsigned TokWords = 4,
  parameter int unsigned TargetW  = 5,
  parameter int unsigned CtrlW    = 1,
  parameter int unsigned VtestW   = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [xl_pkg::AddrW-1:0]     addr_i,
  input  logic [DataW-1:0]             wdata_i,
  output logic [CtrlW-1:0]             ctrl_o,
  output logic [TargetW-1:0]           target_o,
  output logic [VtestW-1:0]            vtest_o,
  output logic [TokWords*DataW-1:0]    token_o,
  output logic                         start_o
);
  import xl_pkg::*;

  logic [CtrlW-1:0]   ctrl_q;
  logic [TargetW-1:0] target_q;
  logic [VtestW-1:0]  vtest_q;
  logic               start_q, start_d;
  logic               ctrl_en, target_en, vtest_en;

  always_comb begin
    ctrl_en   = we_i && (addr_i == A_CTRL);
    target_en = we_i && (addr_i == A_TARGET);
    vtest_en  = we_i && (addr_i == A_VTEST);
    start_d   = we_i && (addr_i == A_CMD) && wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      target_q <= '0;
      vtest_q  <= '0;
      start_q  <= 1'b0;
    end else begin
      if (ctrl_en)   ctrl_q   <= wdata_i[CtrlW-1:0];
      if (target_en) target_q <= wdata_i[TargetW-1:0];
      if (vtest_en)  vtest_q  <= wdata_i[VtestW-1:0];
      start_q <= start_d;
    end
  end

  for (genvar i = 0; i < TokWords; i++) begin : g_tok
    logic [DataW-1:0] word_q;
    logic             word_en;
    assign word_en = we_i && (int'(addr_i) == TokBase + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (word_en) word_q <= wdata_i;
    end
    assign token_o[i*DataW +: DataW] = word_q;
  end

  assign ctrl_o   = ctrl_q;
  assign target_o = target_q;
  assign vtest_o  = vtest_q;
  assign start_o  = start_q;

  AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(target_q) && $stable(ctrl_q) && $stable(vtest_q))); // R8
  AST_START_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> $past(we_i)); // R10
endmodule

// File: rtl/xl_rdmux.sv
module xl_rdmux #(
  parameter int unsigned DataW    = 32,
  parameter int unsigned TokWords = 4,
  parameter int unsigned TargetW  = 5,
  parameter int unsigned CtrlW    = 1,
  parameter int unsigned VtestW   = 32,
  parameter int unsigned ClaimW   = 8,
  parameter logic [ClaimW-1:0] ClaimKey = 8'h5A
) (
  input  logic [xl_pkg::AddrW-1:0]  addr_i,
  input  logic                      owns_i,
  input  logic                      en_i,
  input  logic [CtrlW-1:0]          ctrl_i,
  input  logic [TargetW-1:0]        target_i,
  input  logic [VtestW-1:0]         vtest_i,
  input  logic [TokWords*DataW-1:0] token_i,
  output logic [DataW-1:0]          rdata_o
);
  import xl_pkg::*;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CLAIM:  rdata_o = DataW'(owns_i ? ClaimKey : '0);
      A_EN:     rdata_o = DataW'(en_i);
      A_CTRL:   rdata_o = DataW'(ctrl_i);
      A_TARGET: rdata_o = DataW'(target_i);
      A_VTEST:  rdata_o = DataW'(vtest_i);
      default:  rdata_o = '0;
    endcase
    for (int i = 0; i < int'(TokWords); i++) begin
      if (int'(addr_i) == TokBase + i) rdata_o = token_i[i*DataW +: DataW];
    end
  end
endmodule

// File: rtl/xfer_lock.sv
module xfer_lock #(
  parameter int unsigned DataW    = 32,
  parameter int unsigned TokWords = 4,
  parameter int unsigned TargetW  = 5,
  parameter int unsigned CtrlW    = 1,
  parameter int unsigned VtestW   = 32,
  parameter int unsigned ClaimW   = 8,
  parameter logic [ClaimW-1:0] ClaimKey = 8'h5A
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         busy_i,
  input  logic                         sw_wr_i,
  input  logic [xl_pkg::AddrW-1:0]     sw_addr_i,
  input  logic [DataW-1:0]             sw_wdata_i,
  output logic [DataW-1:0]             sw_rdata_o,
  input  logic                         tap_wr_i,
  input  logic [xl_pkg::AddrW-1:0]     tap_addr_i,
  input  logic [DataW-1:0]             tap_wdata_i,
  output logic [DataW-1:0]             tap_rdata_o,
  output logic                         sw_en_o,
  output logic                         tap_en_o,
  output logic                         start_o,
  output logic [CtrlW-1:0]             ctrl_o,
  output logic [TargetW-1:0]           target_o,
  output logic [VtestW-1:0]            vtest_o,
  output logic [TokWords*DataW-1:0]    token_o
);
  import xl_pkg::*;

  owner_e               owner;
  logic                 sw_owns, tap_owns, sw_we, tap_we, reg_we;
  logic [AddrW-1:0]     reg_addr;
  logic [DataW-1:0]     reg_wdata;

  xl_arbiter #(.ClaimW(ClaimW), .ClaimKey(ClaimKey)) u_arb (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sw_claim_wr_i   (sw_wr_i && (sw_addr_i == A_CLAIM)),
    .sw_claim_val_i  (sw_wdata_i[ClaimW-1:0]),
    .tap_claim_wr_i  (tap_wr_i && (tap_addr_i == A_CLAIM)),
    .tap_claim_val_i (tap_wdata_i[ClaimW-1:0]),
    .owner_o         (owner)
  );

  always_comb begin
    sw_owns   = (owner == OWN_SW);
    tap_owns  = (owner == OWN_TAP);
    sw_en_o   = sw_owns  && !busy_i;
    tap_en_o  = tap_owns && !busy_i;
    sw_we     = sw_wr_i  && sw_en_o  && (sw_addr_i  != A_CLAIM);
    tap_we    = tap_wr_i && tap_en_o && (tap_addr_i != A_CLAIM);
    reg_we    = sw_we || tap_we;
    reg_addr  = tap_we ? tap_addr_i  : sw_addr_i;
    reg_wdata = tap_we ? tap_wdata_i : sw_wdata_i;
  end

  xl_regfile #(
    .DataW(DataW), .TokWords(TokWords), .TargetW(TargetW),
    .CtrlW(CtrlW), .VtestW(VtestW)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .ctrl_o   (ctrl_o),
    .target_o (target_o),
    .vtest_o  (vtest_o),
    .token_o  (token_o),
    .start_o  (start_o)
  );

  xl_rdmux #(
    .DataW(DataW), .TokWords(TokWords), .TargetW(TargetW), .CtrlW(CtrlW),
    .VtestW(VtestW), .ClaimW(ClaimW), .ClaimKey(ClaimKey)
  ) u_rd_sw (
    .addr_i (sw_addr_i), .owns_i (sw_owns), .en_i (sw_en_o),
    .ctrl_i (ctrl_o), .target_i (target_o), .vtest_i (vtest_o),
    .token_i (token_o), .rdata_o (sw_rdata_o)
  );

  xl_rdmux #(
    .DataW(DataW), .TokWords(TokWords), .TargetW(TargetW), .CtrlW(CtrlW),
    .VtestW(VtestW), .ClaimW(ClaimW), .ClaimKey(ClaimKey)
  ) u_rd_tap (
    .addr_i (tap_addr_i), .owns_i (tap_owns), .en_i (tap_en_o),
    .ctrl_i (ctrl_o), .target_i (target_o), .vtest_i (vtest_o),
    .token_i (token_o), .rdata_o (tap_rdata_o)
  );

  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(target_o) && $stable(token_o) && $stable(ctrl_o))); // R7
  AST_NO_START_UNOWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner == OWN_NONE) |=> !start_o); // R10
endmodule

// File: tb/tb_xfer_lock.sv
module tb_xfer_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0;
  logic        sw_wr = 1'b0, tap_wr = 1'b0;
  logic [3:0]  sw_addr = '0, tap_addr = '0;
  logic [31:0] sw_wdata = '0, tap_wdata = '0;
  logic [31:0] sw_rdata, tap_rdata;
  logic        sw_en, tap_en, start;
  logic [0:0]  ctrl;
  logic [4:0]  target;
  logic [31:0] vtest;
  logic [127:0] token;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event  chk_ev;
  int    n_vec = 0, n_bad = 0;
  bit    done = 0;

  always #10 clk = ~clk;

  xfer_lock dut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy),
    .sw_wr_i(sw_wr), .sw_addr_i(sw_addr), .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata),
    .tap_wr_i(tap_wr), .tap_addr_i(tap_addr), .tap_wdata_i(tap_wdata), .tap_rdata_o(tap_rdata),
    .sw_en_o(sw_en), .tap_en_o(tap_en), .start_o(start),
    .ctrl_o(ctrl), .target_o(target), .vtest_o(vtest), .token_o(token)
  );

  // monitor: pops expected items and compares against the observed value
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = sw_rdata;
          1: act = tap_rdata;
          2: act = 32'(sw_en);
          3: act = 32'(tap_en);
          4: act = 32'(start);
          5: act = 32'(target);
          6: act = 32'(ctrl);
          default: act = token[63:32];
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  // kinds: 0 sw read, 1 tap read, 2 sw_en, 3 tap_en, 4 start, 5 target, 6 ctrl, 7 token word 1
  task automatic chk(input int kind, input logic [3:0] addr, input logic [31:0] exp, input string tag);
    item_t it;
    if (kind == 0) sw_addr = addr;
    if (kind == 1) tap_addr = addr;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> chk_ev;
    #2;
  endtask

  task automatic wr(input bit tap, input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk);
    if (tap) begin tap_wr = 1; tap_addr = addr; tap_wdata = data; end
    else     begin sw_wr = 1;  sw_addr = addr;  sw_wdata = data;  end
    @(negedge clk);
    sw_wr = 0; tap_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(0, 4'd0, 32'h0, "R1 sw claim");
    chk(2, 4'd0, 32'h0, "R1 sw_en");
    chk(3, 4'd0, 32'h0, "R1 tap_en");
    chk(4, 4'd0, 32'h0, "R1 start");
    chk(1, 4'd4, 32'h0, "R1 target rd");
    chk(1, 4'd9, 32'h0, "R1 token rd");
    // R8 write without ownership is dropped
    wr(0, 4'd4, 32'h5);
    chk(0, 4'd4, 32'h0, "R8 unowned target");
    // R5 wrong key
    wr(0, 4'd0, 32'h33);
    chk(0, 4'd0, 32'h0, "R5 bad key");
    chk(2, 4'd0, 32'h0, "R5 sw_en");
    // R2 claim by sw
    wr(0, 4'd0, 32'h5A);
    chk(0, 4'd0, 32'h5A, "R2 sw readback");
    chk(2, 4'd0, 32'h1, "R2 sw_en");
    chk(1, 4'd0, 32'h0, "R2 tap readback");
    chk(0, 4'd1, 32'h1, "R11 sw en reg");
    chk(1, 4'd1, 32'h0, "R11 tap en reg");
    // R4 tap claim attempt ignored
    wr(1, 4'd0, 32'h5A);
    chk(1, 4'd0, 32'h0, "R4 tap readback");
    chk(0, 4'd0, 32'h5A, "R4 sw keeps");
    // R6 release by non-owner ignored
    wr(1, 4'd0, 32'h0);
    chk(0, 4'd0, 32'h5A, "R6 foreign release");
    // R8 tap write dropped
    wr(1, 4'd4, 32'h9);
    chk(5, 4'd0, 32'h0, "R8 tap target");
    // R9 owner writes
    wr(0, 4'd4, 32'h13);
    chk(5, 4'd0, 32'h13, "R9 target_o");
    chk(1, 4'd4, 32'h13, "R9 tap sees target");
    for (int i = 0; i < 4; i++) wr(0, 4'(8 + i), 32'h1000 + i);
    chk(1, 4'd10, 32'h1002, "R9 token word 2");
    chk(7, 4'd0, 32'h1001, "R9 token_o word 1");
    // R10 start pulse
    wr(0, 4'd2, 32'h1);
    chk(4, 4'd0, 32'h1, "R10 start high");
    @(negedge clk);
    chk(4, 4'd0, 32'h0, "R10 start one cycle");
    chk(0, 4'd2, 32'h0, "R10 cmd reads 0");
    wr(0, 4'd2, 32'h0);
    chk(4, 4'd0, 32'h0, "R10 zero no pulse");
    // R7 busy
    @(negedge clk);
    busy = 1;
    chk(2, 4'd0, 32'h0, "R7 sw_en busy");
    chk(0, 4'd0, 32'h5A, "R7 owner kept");
    wr(0, 4'd3, 32'h1);
    chk(6, 4'd0, 32'h0, "R7 write dropped");
    busy = 0;
    chk(2, 4'd0, 32'h1, "R7 sw_en back");
    // R6 release by owner
    wr(0, 4'd0, 32'h0);
    chk(0, 4'd0, 32'h0, "R6 released");
    chk(2, 4'd0, 32'h0, "R6 sw_en");
    // R3 simultaneous claim
    @(negedge clk);
    sw_wr = 1; sw_addr = 4'd0; sw_wdata = 32'h5A;
    tap_wr = 1; tap_addr = 4'd0; tap_wdata = 32'h5A;
    @(negedge clk);
    sw_wr = 0; tap_wr = 0;
    chk(1, 4'd0, 32'h5A, "R3 tap wins");
    chk(0, 4'd0, 32'h0, "R3 sw loses");
    chk(3, 4'd0, 32'h1, "R3 tap_en");
    chk(2, 4'd0, 32'h0, "R3 sw_en");
    // R9 tap writes, sw reads
    wr(1, 4'd5, 32'hCAFE0001);
    chk(0, 4'd5, 32'hCAFE0001, "R9 vtest via sw");
    wr(1, 4'd0, 32'h0);
    chk(3, 4'd0, 32'h0, "R6 tap released");
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule